// File: doc/BRIEF.md
# Exchange Request Reflection Sequencer

This block steps a network node through the fixed phase sequence of a system exchange-request exchange. An optional one-round or two-round message exchange may follow it. In the opening phase the node sends its own request data to all peers and writes the same bytes into its local channel-0 receive FIFO. Next come five reflect phases, one for each absolute node A to E, in that order. In each reflect phase the node forwards what it received from that node. The absolute node index is turned into the relative receive channel that holds its copy, which is `(X - self) mod 5`.

Each phase transmits a fixed number of bytes. Each phase also runs a vote-wait timer, loaded when the phase begins, which covers inter-node skew plus FIFO write-to-read latency. When the timer expires, the block checks the enabled receive FIFOs. If all of them hold data, it grants voting and moves to the next phase. If any of them is empty, it flags an error and drops back to idle. A debug loopback mode writes every transmitted byte into all local receive channels, so that one node can be exercised alone.

Top module: `erx_seq`

## Requirements
- R1: While reset is asserted and after its release with no start, every output is zero.
- R2: The first phase after a start lasts BEATS transmit cycles. In each of them `tx_valid_o` is 1, `tx_sel_o` is the own-data code (value 5), no `fifo_rd_o` bit is set, and `rx_wr_o[0]` is 1.
- R3: Reflect phases run for X = 0..4 in increasing order. In phase X each transmit cycle has `tx_sel_o` = (X - id) mod 5 and `fifo_rd_o` one-hot at that bit position, so X equal to the local id reads channel 0.
- R4: Every phase lasts max(BEATS, D) + 1 cycles, where D is `vote_dly_i` sampled with the start. The transmit cycles come first, and the last cycle of the phase is the vote decision cycle. When no FIFO selected by `chan_en_i` is empty there, `vote_o` is 1 for that cycle only.
- R5: If in a decision cycle any channel with both `chan_en_i` and `fifo_empty_i` set exists, `err_o` is 1 instead of `vote_o`. The block then returns to idle, and the next cycle shows all outputs zero with no done.
- R6: With `xclass_i` = 1, one extra own-data phase follows reflect phase 4. It uses the same encoding as R2.
- R7: With `xclass_i` = 2, two extra phases follow. In the first, the node sends its own data only if its id equals `src_id_i`; otherwise all transmit outputs stay 0 for those cycles. In the second, every node reflects channel (src - id) mod 5.
- R8: With `xclass_i` = 0 or 3, the exchange ends after reflect phase 4.
- R9: `done_o` is 1 for exactly one cycle, the cycle after the vote of the final phase.
- R10: While `loop_i` is 1, every transmit cycle has `rx_wr_o` all ones. While it is 0, only bit 0 is set.
- R11: `node_id_i`, `xclass_i`, `src_id_i` and `vote_dly_i` are captured with the start. A start pulse or a changed id during an exchange has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an exchange (accepted when idle) |
| node_id_i | input | 3 | Local node identity, 0..4 |
| xclass_i | input | 2 | 0/3 request only, 1 one-round, 2 two-round |
| src_id_i | input | 3 | Source node of a two-round message |
| vote_dly_i | input | 8 | Vote-wait cycles per phase |
| chan_en_i | input | 5 | Receive channels checked at vote time |
| fifo_empty_i | input | 5 | Empty flags of relative receive channels |
| loop_i | input | 1 | Debug loopback into all receive channels |
| tx_valid_o | output | 1 | A byte is transmitted this cycle |
| tx_sel_o | output | 3 | Transmit source: 0..4 channel, 5 own data |
| fifo_rd_o | output | 5 | Read strobes of relative receive channels |
| rx_wr_o | output | 5 | Local receive-channel write strobes |
| vote_o | output | 1 | Voting may begin |
| err_o | output | 1 | Enabled FIFO empty at vote time; abort |
| done_o | output | 1 | Exchange complete |

## Verification
The bench aims at the modular channel mapping. It uses every local id together with reflect phases both below and above it. A mapping that forgets the wrap would read a nonexistent channel, and a sign error would pick the mirror channel. Vote-wait values shorter than, equal to and longer than the byte count are used, because a timer loaded once per exchange instead of once per phase, or counted from the end of transmission, shifts every later vote.

Empty-FIFO cases are tested on an enabled channel and on a masked one. A missing mask would abort good exchanges, and a missing abort would let `done_o` appear. Two-round runs with the node as source and as non-source, and a start pulse injected mid-exchange with a different id, expose a design that transmits when it should stay silent or that re-latches its identity.

// File: rtl/erx_pkg.sv
package erx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XMIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_DONE = 2'd3
  } erx_state_e;

  typedef enum logic [1:0] {
    XC_NONE = 2'd0,
    XC_ONE  = 2'd1,
    XC_TWO  = 2'd2,
    XC_RSVD = 2'd3
  } erx_class_e;
endpackage

// File: rtl/erx_down_ctr.sv
module erx_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (dec_i & (cnt_q != '0));
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // Without a load the count only moves down (R4 timing base)
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/erx_rel_map.sv
module erx_rel_map #(
  parameter int NODES = 5,
  parameter int IDW   = 3
) (
  input  logic [IDW-1:0] abs_i,
  input  logic [IDW-1:0] self_i,
  output logic [IDW-1:0] rel_o
);
  logic [IDW:0] sum;

  always_comb begin
    sum = {1'b0, abs_i} + (IDW+1)'(NODES) - {1'b0, self_i};
    if (sum >= (IDW+1)'(NODES)) rel_o = IDW'(sum - (IDW+1)'(NODES));
    else                        rel_o = IDW'(sum);
  end
endmodule

// File: rtl/erx_seq.sv
module erx_seq
  import erx_pkg::*;
#(
  parameter int NODES = 5,
  parameter int BEATS = 4,
  parameter int DLY_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [$clog2(NODES+1)-1:0]       node_id_i,
  input  logic [1:0]                       xclass_i,
  input  logic [$clog2(NODES+1)-1:0]       src_id_i,
  input  logic [DLY_W-1:0]                 vote_dly_i,
  input  logic [NODES-1:0]                 chan_en_i,
  input  logic [NODES-1:0]                 fifo_empty_i,
  input  logic                             loop_i,
  output logic                             tx_valid_o,
  output logic [$clog2(NODES+1)-1:0]       tx_sel_o,
  output logic [NODES-1:0]                 fifo_rd_o,
  output logic [NODES-1:0]                 rx_wr_o,
  output logic                             vote_o,
  output logic                             err_o,
  output logic                             done_o
);
  localparam int ID_W = $clog2(NODES+1);
  localparam int PH_W = $clog2(NODES+3);
  localparam int BT_W = $clog2(BEATS+1);
  localparam logic [ID_W-1:0] OWN_SEL = ID_W'(NODES);
  localparam logic [PH_W-1:0] PH_MSG1 = PH_W'(NODES+1);
  localparam logic [PH_W-1:0] PH_MSG2 = PH_W'(NODES+2);

  erx_state_e        state_q, state_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [ID_W-1:0]   id_q, src_q;
  erx_class_e        cls_q;
  logic [DLY_W-1:0]  dly_q;
  logic              cap_en, ph_en;

  logic              beat_zero, dly_zero;
  logic              enter_phase;
  logic [DLY_W-1:0]  dly_load;
  logic [PH_W-1:0]   last_ph;
  logic              ph_refl, ph_r1, ph_r2, sending, bad, hold_exp;
  logic [ID_W-1:0]   abs_sel, rel_ch;

  // phase decode
  always_comb begin
    case (cls_q)
      XC_ONE:  last_ph = PH_MSG1;
      XC_TWO:  last_ph = PH_MSG2;
      default: last_ph = PH_W'(NODES);
    endcase
    ph_refl  = (phase_q >= PH_W'(1)) && (phase_q <= PH_W'(NODES));
    ph_r1    = (phase_q == PH_MSG1) && (cls_q == XC_TWO);
    ph_r2    = (phase_q == PH_MSG2);
    sending  = !(ph_r1 && (id_q != src_q));
    abs_sel  = ph_r2 ? src_q : ID_W'(phase_q - PH_W'(1));
    bad      = |(chan_en_i & fifo_empty_i);
    hold_exp = (state_q == ST_HOLD) && dly_zero;
  end

  erx_rel_map #(.NODES(NODES), .IDW(ID_W)) u_map (
    .abs_i  (abs_sel),
    .self_i (id_q),
    .rel_o  (rel_ch)
  );

  // next state
  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    enter_phase = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d     = ST_XMIT;
        phase_d     = '0;
        enter_phase = 1'b1;
      end
      ST_XMIT: if (beat_zero) state_d = ST_HOLD;
      ST_HOLD: if (dly_zero) begin
        if (bad)                       state_d = ST_IDLE;
        else if (phase_q == last_ph)   state_d = ST_DONE;
        else begin
          state_d     = ST_XMIT;
          phase_d     = phase_q + PH_W'(1);
          enter_phase = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cap_en   = (state_q == ST_IDLE) && start_i;
  assign ph_en    = enter_phase;
  assign dly_load = (state_q == ST_IDLE) ? vote_dly_i : dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (ph_en) phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      src_q <= '0;
      cls_q <= XC_NONE;
      dly_q <= '0;
    end else if (cap_en) begin
      id_q  <= node_id_i;
      src_q <= src_id_i;
      cls_q <= erx_class_e'(xclass_i);
      dly_q <= vote_dly_i;
    end
  end

  erx_down_ctr #(.W(BT_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (enter_phase),
    .load_val_i (BT_W'(BEATS-1)),
    .dec_i      (state_q == ST_XMIT),
    .zero_o     (beat_zero)
  );

  erx_down_ctr #(.W(DLY_W)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (enter_phase),
    .load_val_i (dly_load),
    .dec_i      (1'b1),
    .zero_o     (dly_zero)
  );

  // outputs
  always_comb begin
    tx_valid_o = (state_q == ST_XMIT) && sending;
    tx_sel_o   = '0;
    fifo_rd_o  = '0;
    rx_wr_o    = '0;
    if (tx_valid_o) begin
      rx_wr_o = {{(NODES-1){loop_i}}, 1'b1};
      if (ph_refl || ph_r2) begin
        tx_sel_o  = rel_ch;
        fifo_rd_o = NODES'(1) << rel_ch;
      end else begin
        tx_sel_o  = OWN_SEL;
      end
    end
    vote_o = hold_exp && !bad;
    err_o  = hold_exp && bad;
    done_o = (state_q == ST_DONE);
  end

  assert_rd_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_rd_o));
  assert_rd_needs_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_rd_o) |-> (tx_valid_o && (tx_sel_o < OWN_SEL)));
  assert_vote_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(vote_o && err_o));
  assert_err_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (!tx_valid_o && !done_o && !vote_o));
  assert_done_after_vote_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(vote_o));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_ch0_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> rx_wr_o[0]);
endmodule

// File: tb/erx_seq_tb.sv
module erx_seq_tb_top;
  localparam int BEATS = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [2:0] node_id_i, src_id_i;
  logic [1:0] xclass_i;
  logic [7:0] vote_dly_i;
  logic [4:0] chan_en_i, fifo_empty_i;
  logic       loop_i;
  logic       tx_valid_o, vote_o, err_o, done_o;
  logic [2:0] tx_sel_o;
  logic [4:0] fifo_rd_o, rx_wr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  erx_seq #(.NODES(5), .BEATS(BEATS), .DLY_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .node_id_i(node_id_i),
    .xclass_i(xclass_i), .src_id_i(src_id_i), .vote_dly_i(vote_dly_i),
    .chan_en_i(chan_en_i), .fifo_empty_i(fifo_empty_i), .loop_i(loop_i),
    .tx_valid_o(tx_valid_o), .tx_sel_o(tx_sel_o), .fifo_rd_o(fifo_rd_o),
    .rx_wr_o(rx_wr_o), .vote_o(vote_o), .err_o(err_o), .done_o(done_o)
  );

  // stimulus vector: id, class, src, delay, loop, fail phase (15 none), fail channel, enable mask
  localparam int NV = 8;
  localparam logic [28:0] VECS [NV] = '{
    {3'd0, 2'd0, 3'd0, 8'd0,  1'b0, 4'd15, 3'd0, 5'h1f},
    {3'd1, 2'd1, 3'd0, 8'd2,  1'b0, 4'd15, 3'd0, 5'h1f},
    {3'd2, 2'd2, 3'd2, 8'd4,  1'b0, 4'd15, 3'd0, 5'h1f},
    {3'd3, 2'd2, 3'd1, 8'd9,  1'b0, 4'd15, 3'd0, 5'h1f},
    {3'd4, 2'd3, 3'd0, 8'd6,  1'b1, 4'd15, 3'd0, 5'h1f},
    {3'd4, 2'd1, 3'd3, 8'd3,  1'b1, 4'd15, 3'd0, 5'h1f},
    {3'd0, 2'd2, 3'd4, 8'd0,  1'b0, 4'd15, 3'd0, 5'h1f},
    {3'd2, 2'd0, 3'd1, 8'd5,  1'b0, 4'd2,  3'd1, 5'h1d}
  };

  function automatic logic [16:0] outs();
    return {tx_valid_o, tx_sel_o, fifo_rd_o, rx_wr_o, vote_o, err_o, done_o};
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int relch(input int a, input int self);
    return (a + 5 - self) % 5;
  endfunction

  task automatic run_xchg(input logic [28:0] v, input bit poke);
    int id, cls, src, dly, fph, fch, last, plen;
    bit lp, aborted;
    logic [4:0] en;
    id = v[28:26]; cls = v[25:24]; src = v[23:21]; dly = v[20:13];
    lp = v[12]; fph = v[11:8]; fch = v[7:5]; en = v[4:0];
    last = (cls == 1) ? 6 : (cls == 2) ? 7 : 5;
    plen = ((dly > BEATS) ? dly : BEATS) + 1;
    aborted = 1'b0;
    @(negedge clk);
    node_id_i = 3'(id); xclass_i = 2'(cls); src_id_i = 3'(src);
    vote_dly_i = 8'(dly); loop_i = lp; chan_en_i = en; fifo_empty_i = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int p = 0; p <= last && !aborted; p++) begin
      fifo_empty_i = (p == fph) ? 5'(1 << fch) : 5'b0;
      for (int c = 0; c < plen; c++) begin
        bit xm, snd, fail, refl;
        int sel;
        logic [16:0] e;
        xm   = (c < BEATS);
        snd  = !(p == 6 && cls == 2 && id != src);
        refl = (p >= 1 && p <= 5) || p == 7;
        sel  = (p >= 1 && p <= 5) ? relch(p - 1, id) : (p == 7) ? relch(src, id) : 5;
        fail = (p == fph) && en[fch];
        e = '0;
        if (xm && snd) begin
          e[16]    = 1'b1;
          e[15:13] = 3'(sel);
          e[12:8]  = refl ? 5'(1 << sel) : 5'b0;
          e[7:3]   = lp ? 5'h1f : 5'h01;
        end
        if (c == plen - 1) begin
          e[2] = !fail;
          e[1] = fail;
        end
        if (p == 0)                chk("R2 own phase", outs(), e);
        else if (p <= 5)           chk("R3 reflect phase", outs(), e);
        else if (cls == 1)         chk("R6 one-round phase", outs(), e);
        else                       chk("R7 two-round phase", outs(), e);
        if (c == plen - 1)         chk(fail ? "R5 error decision" : "R4 vote decision", outs(), e);
        if (poke && p == 2 && c == 1) begin
          start_i = 1'b1; node_id_i = 3'((id + 2) % 5);
        end else begin
          start_i = 1'b0;
        end
        if (fail) aborted = (c == plen - 1);
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    fifo_empty_i = '0;
    if (aborted) begin
      chk("R5 idle after abort", outs(), 17'h0);
    end else begin
      chk((cls == 0 || cls == 3) ? "R8 done after E" : "R9 done pulse", outs(), 17'h1);
      @(negedge clk);
      chk("R9 done single cycle", outs(), 17'h0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; node_id_i = '0; xclass_i = '0; src_id_i = '0;
    vote_dly_i = '0; chan_en_i = 5'h1f; fifo_empty_i = '0; loop_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", outs(), 17'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle outputs", outs(), 17'h0);

    for (int i = 0; i < NV; i++) run_xchg(VECS[i], 1'b0);

    // abort on enabled empty channel in reflect phase C
    run_xchg({3'd1, 2'd1, 3'd0, 8'd3, 1'b0, 4'd3, 3'd2, 5'h1f}, 1'b0);
    // abort in final two-round phase
    run_xchg({3'd3, 2'd2, 3'd0, 8'd1, 1'b0, 4'd7, 3'd4, 5'h1f}, 1'b0);
    // empty but masked channel must not abort
    run_xchg({3'd0, 2'd0, 3'd0, 8'd7, 1'b0, 4'd4, 3'd3, 5'h17}, 1'b0);
    // R11 start pulse and id change mid-exchange are ignored
    run_xchg({3'd1, 2'd2, 3'd3, 8'd5, 1'b1, 4'd15, 3'd0, 5'h1f}, 1'b1);
    // R1 after all runs: back to idle
    chk("R1 idle after runs", outs(), 17'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule